// File: doc/BRIEF.md
# Receive Queue with Per-Character Error Status

This block sits between a serial deserializer and a processor bus. Every time the deserializer finishes a character it pulses a valid strobe, presenting the raw character bits, the received parity bit, a framing-error tag and a break tag. The block works out the parity error itself, using the current word-length and parity settings. It then pushes the character, with its three error tags, into a first-in first-out queue. The processor sees the oldest character and a five-bit line status word. It pops characters with a data-read strobe and acknowledges errors with a status-read strobe. A line-status interrupt request is raised whenever an error bit is showing.

The error tags travel with their character through the queue. They become visible in the status word only when that character reaches the head. A lost character is the exception: the overrun flag is raised at once, in the cycle after the character that could not be stored. Queue occupancy is tracked by a three-state machine. The states are `OCC_EMPTY`, `OCC_PARTIAL` and `OCC_FULL`. There are four transitions:
- fill: `OCC_EMPTY` to `OCC_PARTIAL`, on a push.
- top-off: `OCC_PARTIAL` to `OCC_FULL`, on a push without a pop while one slot is left.
- release: `OCC_FULL` to `OCC_PARTIAL`, on a pop without a push.
- drain: `OCC_PARTIAL` to `OCC_EMPTY`, on a pop without a push while one character is left.

In every other case the machine holds its state.

Top module: `rxq_line_status`

## Requirements
- R1: Status bit 0 (data ready) is 1 in the cycle after a character is stored. It returns to 0 only after a data read has removed the last stored character.
- R2: Characters leave in arrival order, and up to `FIFO_DEPTH` (16) are held. `head_char` reads 0 while the queue is empty. A data read on an empty queue changes nothing.
- R3: A character arriving while the queue holds `FIFO_DEPTH` characters, with no data read in the same cycle, is discarded and sets status bit 1 (overrun). If a data read happens in that same cycle, the character is stored and no overrun is flagged.
- R4: The overrun flag is visible in the cycle after the discarded character arrives, however many characters are still queued.
- R5: A status read clears bit 1. It also clears the error tags of the character at the head, which are shown in bits 2 to 4. An overrun, or a tagged character entering an empty queue, in the same cycle as the status read leaves its flag set.
- R6: Status bit 2 (parity error) shows the parity tag of the head character only. A tagged character that is not yet at the head does not set the bit.
- R7: The expected parity bit depends on the parity settings:
  - parity disabled (`cfg_par_en`=0): never a parity error.
  - stick parity (`cfg_par_stick`=1): 0 when `cfg_par_even`=1, and 1 when `cfg_par_even`=0.
  - otherwise, even parity (`cfg_par_even`=1): the XOR of the active data bits.
  - otherwise, odd parity: the complement of that XOR.
  A mismatch with `rx_par_bit` tags the character.
- R8: `cfg_wlen` selects 5, 6, 7 or 8 data bits (encodings 0 to 3). Bits above the word length are stored and shown as 0, and they are excluded from the parity calculation.
- R9: Status bit 3 shows the framing tag of the head character, and status bit 4 shows its break tag.
- R10: `lsi_req` is 1 exactly while any of status bits 1 to 4 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wlen | input | 2 | Word length: 0=5, 1=6, 2=7, 3=8 bits |
| cfg_par_en | input | 1 | Parity checking enabled |
| cfg_par_even | input | 1 | Even parity select |
| cfg_par_stick | input | 1 | Stick parity select |
| rx_valid | input | 1 | One-cycle strobe: a character has completed |
| rx_char | input | 8 | Received character bits, LSB first bit |
| rx_par_bit | input | 1 | Received parity bit |
| rx_frm_err | input | 1 | Framing-error tag from deserializer |
| rx_brk | input | 1 | Break tag from deserializer |
| cpu_rd_data | input | 1 | Data read strobe: pops the head character |
| cpu_rd_stat | input | 1 | Status read strobe: clears error flags |
| head_char | output | 8 | Character at the head of the queue |
| line_stat | output | 5 | {break, framing, parity, overrun, data ready} |
| lsi_req | output | 1 | Line-status interrupt request |

## Verification
The hardest situations to reach are at the full boundary. These are an overrun and a status read landing in the same cycle, and a push that coincides with a pop while the queue is full. The bench reaches them by filling the queue with 16 numbered characters, then driving the colliding strobes in a single cycle. It then drains the queue, checking every character and its order. This proves what was stored and what was dropped. A sweep over every word length, every parity setting, both received parity bits and a set of data patterns checks the tag the head character carries.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int CHAR_W = 8;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_t;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [CHAR_W-1:0] data;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_parity_chk.sv
module rxq_parity_chk
    import rxq_pkg::*;
(
    input  logic [1:0]        wlen,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              par_stick,
    input  logic [CHAR_W-1:0] char_in,
    input  logic              par_bit,
    output logic [CHAR_W-1:0] char_out,
    output logic              perr
);
    localparam int MIN_BITS = 5;

    logic [CHAR_W-1:0] keep;
    logic              ones_odd;
    logic              want;

    always_comb begin
        for (int i = 0; i < CHAR_W; i++) begin
            keep[i] = (i < MIN_BITS + int'(wlen));
        end
        char_out = char_in & keep;
        ones_odd = ^char_out;
        if (par_stick) begin
            want = ~par_even;
        end else if (par_even) begin
            want = ones_odd;
        end else begin
            want = ~ones_odd;
        end
        perr = par_en && (par_bit != want);
    end
endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic       pop,
    input  logic       clr_tags,
    input  rxq_entry_t wr_entry,
    output rxq_entry_t head_entry
);
    rxq_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (clr_tags) begin
                mem[rd_ptr].perr <= 1'b0;
                mem[rd_ptr].ferr <= 1'b0;
                mem[rd_ptr].brk  <= 1'b0;
            end
            if (push) begin
                mem[wr_ptr] <= wr_entry;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
        end
    end

    assign head_entry = mem[rd_ptr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_valid,
    input  logic rd_data,
    input  logic rd_stat,
    output logic push,
    output logic pop,
    output logic nonempty,
    output logic full,
    output logic ovr_flag
);
    occ_state_t       state;
    occ_state_t       nxt;
    logic [CNT_W-1:0] count;
    logic             ovr_evt;

    // State register and the counters that travel with it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= OCC_EMPTY;
            count    <= '0;
            ovr_flag <= 1'b0;
        end else begin
            state <= nxt;
            if (push && !pop) begin
                count <= count + 1'b1;
            end else if (pop && !push) begin
                count <= count - 1'b1;
            end
            if (ovr_evt) begin
                ovr_flag <= 1'b1;
            end else if (rd_stat) begin
                ovr_flag <= 1'b0;
            end
        end
    end

    // Outputs and next state
    always_comb begin
        nonempty = (state != OCC_EMPTY);
        full     = (state == OCC_FULL);
        push     = rx_valid && (!full || rd_data);
        pop      = rd_data && nonempty;
        ovr_evt  = rx_valid && full && !rd_data;
        nxt      = state;
        unique case (state)
            OCC_EMPTY: begin
                if (push) nxt = OCC_PARTIAL;                 // fill
            end
            OCC_PARTIAL: begin
                if (push && !pop && count == CNT_W'(DEPTH - 1)) begin
                    nxt = OCC_FULL;                          // top-off
                end else if (pop && !push && count == CNT_W'(1)) begin
                    nxt = OCC_EMPTY;                         // drain
                end
            end
            OCC_FULL: begin
                if (pop && !push) nxt = OCC_PARTIAL;         // release
            end
            default: nxt = OCC_EMPTY;
        endcase
    end
endmodule

// File: rtl/rxq_line_status.sv
module rxq_line_status
    import rxq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  cfg_wlen,
    input  logic        cfg_par_en,
    input  logic        cfg_par_even,
    input  logic        cfg_par_stick,
    input  logic        rx_valid,
    input  logic [7:0]  rx_char,
    input  logic        rx_par_bit,
    input  logic        rx_frm_err,
    input  logic        rx_brk,
    input  logic        cpu_rd_data,
    input  logic        cpu_rd_stat,
    output logic [7:0]  head_char,
    output logic [4:0]  line_stat,
    output logic        lsi_req
);
    logic [CHAR_W-1:0] char_clean;
    logic              char_perr;
    logic              do_push;
    logic              do_pop;
    logic              occ_nonempty;
    logic              occ_full;
    logic              ovr_flag;
    rxq_entry_t        new_entry;
    rxq_entry_t        head;

    rxq_parity_chk u_par (
        .wlen      (cfg_wlen),
        .par_en    (cfg_par_en),
        .par_even  (cfg_par_even),
        .par_stick (cfg_par_stick),
        .char_in   (rx_char),
        .par_bit   (rx_par_bit),
        .char_out  (char_clean),
        .perr      (char_perr)
    );

    rxq_ctrl #(.DEPTH(FIFO_DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rd_data  (cpu_rd_data),
        .rd_stat  (cpu_rd_stat),
        .push     (do_push),
        .pop      (do_pop),
        .nonempty (occ_nonempty),
        .full     (occ_full),
        .ovr_flag (ovr_flag)
    );

    assign new_entry = '{brk: rx_brk, ferr: rx_frm_err, perr: char_perr, data: char_clean};

    rxq_store #(.DEPTH(FIFO_DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (do_push),
        .pop        (do_pop),
        .clr_tags   (cpu_rd_stat && occ_nonempty),
        .wr_entry   (new_entry),
        .head_entry (head)
    );

    always_comb begin
        head_char = occ_nonempty ? head.data : '0;
        line_stat = {head.brk  && occ_nonempty,
                     head.ferr && occ_nonempty,
                     head.perr && occ_nonempty,
                     ovr_flag,
                     occ_nonempty};
        lsi_req   = |line_stat[4:1];
    end
endmodule

// File: rtl/rxq_line_status_chk.sv
module rxq_line_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       cpu_rd_data,
    input logic       cpu_rd_stat,
    input logic [7:0] head_char,
    input logic [4:0] line_stat,
    input logic       lsi_req,
    input logic       occ_full
);
    assert_dr_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_stat[0]) |-> $past(cpu_rd_data));

    assert_head_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stat[0] && !cpu_rd_data) |=> (head_char == $past(head_char)));

    assert_ovr_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_stat[1]) |-> $past(rx_valid && occ_full && !cpu_rd_data));

    assert_stat_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_stat && !rx_valid) |=> !line_stat[1]);

    assert_irq_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lsi_req) |-> $past(cpu_rd_stat || cpu_rd_data));
endmodule

bind rxq_line_status rxq_line_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .cpu_rd_data (cpu_rd_data),
    .cpu_rd_stat (cpu_rd_stat),
    .head_char   (head_char),
    .line_stat   (line_stat),
    .lsi_req     (lsi_req),
    .occ_full    (occ_full)
);

// File: tb/test_rxq_line_status.sv
module test_rxq_line_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_par_stick = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_char = '0;
    logic       rx_par_bit = 1'b0, rx_frm_err = 1'b0, rx_brk = 1'b0;
    logic       cpu_rd_data = 1'b0, cpu_rd_stat = 1'b0;
    logic [7:0] head_char;
    logic [4:0] line_stat;
    logic       lsi_req;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rxq_line_status i_rxq_line_status (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle of strobes after a falling edge; results are read at the next falling edge.
    task automatic cyc(input logic v, input logic [7:0] c, input logic pb, input logic fe,
                       input logic bk, input logic rd, input logic rs);
        rx_valid = v; rx_char = c; rx_par_bit = pb; rx_frm_err = fe; rx_brk = bk;
        cpu_rd_data = rd; cpu_rd_stat = rs;
        @(negedge clk);
        rx_valid = 0; cpu_rd_data = 0; cpu_rd_stat = 0; rx_frm_err = 0; rx_brk = 0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset stat", int'(line_stat), 0);
        check("R10 reset irq", int'(lsi_req), 0);
        check("R2 reset head", int'(head_char), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7/R8 sweep over word length, parity settings, data and received parity bit
        for (int wl = 0; wl < 4; wl++) begin
            for (int cf = 0; cf < 8; cf++) begin
                for (int di = 0; di < 6; di++) begin
                    for (int pb = 0; pb < 2; pb++) begin
                        logic [7:0] d, m;
                        int ones, expbit, experr;
                        case (di)
                            0: d = 8'h00; 1: d = 8'h01; 2: d = 8'h5A;
                            3: d = 8'hFF; 4: d = 8'h80; default: d = 8'h37;
                        endcase
                        m = 8'((1 << (wl + 5)) - 1);
                        ones = $countones(d & m);
                        cfg_wlen = 2'(wl);
                        cfg_par_en = cf[0]; cfg_par_even = cf[1]; cfg_par_stick = cf[2];
                        if (cf[2]) expbit = cf[1] ? 0 : 1;
                        else expbit = cf[1] ? (ones % 2) : 1 - (ones % 2);
                        experr = (cf[0] && pb != expbit) ? 1 : 0;
                        cyc(1, d, 1'(pb), 0, 0, 0, 0);
                        check("R8 masked char", int'(head_char), int'(d & m));
                        check("R7 parity tag", int'(line_stat[2]), experr);
                        check("R10 irq follows parity", int'(lsi_req), experr);
                        cyc(0, 0, 0, 0, 0, 1, 1);
                        check("R1 dr cleared after last read", int'(line_stat[0]), 0);
                    end
                end
            end
        end

        // R6: parity error visible only at the head
        cfg_wlen = 2'd3; cfg_par_en = 1; cfg_par_even = 1; cfg_par_stick = 0;
        cyc(1, 8'h03, 0, 0, 0, 0, 0);
        cyc(1, 8'h01, 0, 0, 0, 0, 0);
        check("R6 tagged char behind head", int'(line_stat[2]), 0);
        check("R1 dr set", int'(line_stat[0]), 1);
        cyc(0, 0, 0, 0, 0, 1, 0);
        check("R6 tagged char at head", int'(line_stat[2]), 1);
        check("R1 dr kept while one left", int'(line_stat[0]), 1);
        cyc(0, 0, 0, 0, 0, 0, 1);
        check("R5 stat read clears parity", int'(line_stat[2]), 0);
        check("R10 irq drops", int'(lsi_req), 0);
        check("R5 stat read keeps data", int'(head_char), 8'h01);
        cyc(0, 0, 0, 0, 0, 1, 0);
        cfg_par_en = 0;

        // R5: tagged char entering empty queue during a status read keeps its tag
        cfg_par_en = 1;
        cyc(1, 8'h01, 0, 0, 0, 0, 1);
        check("R5 new tag wins", int'(line_stat[2]), 1);
        cyc(0, 0, 0, 0, 0, 1, 1);
        cfg_par_en = 0;

        // R9: framing and break tags
        cyc(1, 8'h11, 0, 1, 0, 0, 0);
        check("R9 framing bit", int'(line_stat[3]), 1);
        check("R10 irq on framing", int'(lsi_req), 1);
        cyc(0, 0, 0, 0, 0, 0, 1);
        check("R9 framing cleared", int'(line_stat[3]), 0);
        check("R1 dr after stat read", int'(line_stat[0]), 1);
        cyc(0, 0, 0, 0, 0, 1, 0);
        cyc(1, 8'h00, 0, 0, 1, 0, 0);
        check("R9 break bit", int'(line_stat[4]), 1);
        check("R9 no framing with break", int'(line_stat[3]), 0);
        cyc(0, 0, 0, 0, 0, 1, 1);
        check("R9 break gone", int'(line_stat[4]), 0);

        // R2: read on empty queue is ignored
        cyc(0, 0, 0, 0, 0, 1, 0);
        check("R2 empty read dr", int'(line_stat[0]), 0);
        check("R2 empty read head", int'(head_char), 0);
        cyc(1, 8'h42, 0, 0, 0, 0, 0);
        check("R2 push after empty read", int'(head_char), 8'h42);
        cyc(0, 0, 0, 0, 0, 1, 0);

        // R3/R4: fill to depth, overrun, drain
        for (int i = 0; i < 16; i++) cyc(1, 8'(8'h20 + i), 0, 0, 0, 0, 0);
        check("R3 no overrun at depth", int'(line_stat[1]), 0);
        cyc(1, 8'hEE, 0, 0, 0, 0, 0);
        check("R4 overrun immediate", int'(line_stat[1]), 1);
        check("R10 irq on overrun", int'(lsi_req), 1);
        for (int i = 0; i < 16; i++) begin
            check("R2 order", int'(head_char), 8'h20 + i);
            cyc(0, 0, 0, 0, 0, 1, 0);
        end
        check("R3 dropped char not stored", int'(line_stat[0]), 0);
        check("R5 overrun held until stat read", int'(line_stat[1]), 1);
        cyc(0, 0, 0, 0, 0, 0, 1);
        check("R5 overrun cleared", int'(line_stat[1]), 0);
        check("R10 irq cleared", int'(lsi_req), 0);

        // R5: overrun coinciding with status read; R3: push with pop while full
        for (int i = 0; i < 16; i++) cyc(1, 8'(8'h60 + i), 0, 0, 0, 0, 0);
        cyc(1, 8'hAA, 0, 0, 0, 0, 1);
        check("R5 overrun beats stat read", int'(line_stat[1]), 1);
        cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(1, 8'hBB, 0, 0, 0, 1, 0);
        check("R3 push with pop no overrun", int'(line_stat[1]), 0);
        check("R2 head moved", int'(head_char), 8'h61);
        for (int i = 1; i < 16; i++) begin
            check("R2 order after swap", int'(head_char), 8'h60 + i);
            cyc(0, 0, 0, 0, 0, 1, 0);
        end
        check("R3 accepted char last", int'(head_char), 8'hBB);
        cyc(0, 0, 0, 0, 0, 1, 0);
        check("R1 dr clear at end", int'(line_stat[0]), 0);

        summary();
    end
endmodule